// File: doc/BRIEF.md
# Quad Line Thermal Protection Controller

This block decides, cycle by cycle, which of four line power switches may conduct. A host writes a four-bit enable word and an interrupt-enable bit; the block merges those commands with per-line current-overload flags and two die-temperature warnings. The warnings come at a lower and at a higher threshold. The lower warning trips only the lines that are overloaded at that moment. The higher warning trips every line and raises a global over-temperature flag.

Trips are remembered in a per-line trip register, where 1 means operational and 0 means tripped. A tripped line stays off until the host has turned that line's enable bit off and the higher warning has gone. The host can read back the commanded enables, the trip register, the over-temperature flag and the actual switch state. An active-low interrupt reports overload, but only on lines whose switch is really on.

All detector inputs are asynchronous, active-high, already-digital signals. Each one passes through a two-flop synchronizer before the logic uses it. The external reset is asserted asynchronously and released in step with the clock.

Top module: `quad_thermal_guard`

## Requirements
- R1: After reset every switch output is 0, the enable readback is 0000, the trip readback is 1111, the over-temperature flag is 0 and the interrupt output is 1 (inactive).
- R2: Switch output bit n is 1 exactly when enable bit n is 1 and trip bit n is 1. Bit n of every four-bit vector belongs to line n.
- R3: While the synchronized lower warning is 1, each line whose overload bit is 1 gets trip bit 0 and switches off. Lines without overload keep their trip bit and switch state.
- R4: While the synchronized higher warning is 1, all four trip bits become 0 and all switches turn off.
- R5: A trip bit that is 0 stays 0 after both warnings and the overload have cleared, as long as that line's enable bit stays 1.
- R6: A trip bit returns to 1 only after that line's enable bit has been 0 for a cycle, and never while the higher warning is active.
- R7: The over-temperature flag follows the higher warning through the two-flop synchronizer, so it is 1 while the warning is present and 0 once it has gone. The host cannot write it.
- R8: The interrupt output is 0 when the interrupt-enable bit is 1 and some line has both its overload bit and its switch output at 1. It is not latched.
- R9: The interrupt output returns to 1 when the overload clears, when a thermal trip turns the overloaded line off, when the host turns that line off, or when the interrupt-enable bit is written 0.
- R10: Thermal trips win over host writes. An enable write that sets a bit whose trip bit is 0 updates the enable readback but leaves that switch off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_wr_i | input | 1 | Strobe: load en_wdata_i into the enable register |
| en_wdata_i | input | 4 | New per-line enable word |
| irq_en_wr_i | input | 1 | Strobe: load irq_en_wdata_i into the interrupt-enable bit |
| irq_en_wdata_i | input | 1 | New interrupt-enable value |
| ovl_raw_i | input | 4 | Asynchronous per-line current-overload flags |
| hot_lo_raw_i | input | 1 | Asynchronous lower-threshold temperature warning |
| hot_hi_raw_i | input | 1 | Asynchronous higher-threshold temperature warning |
| sw_on_o | output | 4 | Actual switch state per line |
| en_o | output | 4 | Readback of the commanded enable register |
| trip_ok_o | output | 4 | Readback of the latched trip register (1 = operational) |
| temp_hi_o | output | 1 | Global over-temperature flag |
| irq_n_o | output | 1 | Active-low overload interrupt |

## Verification
A corrupted trip register shows at two ports, sw_on_o and trip_ok_o, within one cycle of the update. The check is made three edges after a detector input changes, which covers the two synchronizer flops and the trip flop. The bench therefore checks for latching across the periods in which all detectors are idle. An error would show there as a line that comes back on without the host's disable, or that stays dark after a valid re-enable. A wrong gating of the interrupt shows at irq_n_o two cycles after the overload input changes, or one cycle after an enable write.

// File: rtl/qtg_pkg.sv
package qtg_pkg;
  localparam int unsigned QTG_LINES_DEF = 4;
  localparam int unsigned QTG_SYNC_DEF  = 2;
endpackage

// File: rtl/qtg_sync.sv
module qtg_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = qtg_pkg::QTG_SYNC_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [DEPTH-1:0][W-1:0] stage_q;
  logic [DEPTH-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < DEPTH; i++) stage_d[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/qtg_trip.sv
module qtg_trip #(
  parameter int unsigned N = qtg_pkg::QTG_LINES_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_q_i,
  input  logic [N-1:0] ovl_s_i,
  input  logic         hot_lo_s_i,
  input  logic         hot_hi_s_i,
  output logic [N-1:0] trip_ok_o
);
  logic [N-1:0] trip_q;
  logic [N-1:0] trip_d;

  // Priority per line: high trip, low trip on overload, restore after disable, hold.
  always_comb begin
    for (int n = 0; n < N; n++) begin
      if (hot_hi_s_i)                    trip_d[n] = 1'b0;
      else if (hot_lo_s_i && ovl_s_i[n]) trip_d[n] = 1'b0;
      else if (!en_q_i[n])               trip_d[n] = 1'b1;
      else                               trip_d[n] = trip_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= '1;
    else        trip_q <= trip_d;
  end

  assign trip_ok_o = trip_q;

  assert_hi_trips_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hot_hi_s_i |=> (trip_q == '0));

  for (genvar g = 0; g < N; g++) begin : g_chk
    assert_lo_trips_ovl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_lo_s_i && ovl_s_i[g]) |=> !trip_q[g]);
    assert_restore_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip_q[g]) |-> (!$past(en_q_i[g]) && !$past(hot_hi_s_i)));
    assert_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!trip_q[g] && en_q_i[g]) |=> !trip_q[g]);
  end
endmodule

// File: rtl/quad_thermal_guard.sv
module quad_thermal_guard #(
  parameter int unsigned N_LINES    = qtg_pkg::QTG_LINES_DEF,
  parameter int unsigned SYNC_DEPTH = qtg_pkg::QTG_SYNC_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr_i,
  input  logic [N_LINES-1:0] en_wdata_i,
  input  logic               irq_en_wr_i,
  input  logic               irq_en_wdata_i,
  input  logic [N_LINES-1:0] ovl_raw_i,
  input  logic               hot_lo_raw_i,
  input  logic               hot_hi_raw_i,
  output logic [N_LINES-1:0] sw_on_o,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] trip_ok_o,
  output logic               temp_hi_o,
  output logic               irq_n_o
);
  localparam int unsigned DET_W = N_LINES + 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Detector synchronizers.
  logic [DET_W-1:0]   det_s;
  logic [N_LINES-1:0] ovl_s;
  logic               hot_lo_s;
  logic               hot_hi_s;

  qtg_sync #(.W(DET_W), .DEPTH(SYNC_DEPTH)) u_det_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({hot_hi_raw_i, hot_lo_raw_i, ovl_raw_i}),
    .q_o   (det_s)
  );
  assign ovl_s    = det_s[N_LINES-1:0];
  assign hot_lo_s = det_s[N_LINES];
  assign hot_hi_s = det_s[N_LINES+1];

  // Host registers with explicit clock enables.
  logic [N_LINES-1:0] en_q, en_d;
  logic               irq_en_q, irq_en_d;

  always_comb begin
    en_d     = en_wr_i     ? en_wdata_i     : en_q;
    irq_en_d = irq_en_wr_i ? irq_en_wdata_i : irq_en_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q     <= '0;
      irq_en_q <= 1'b0;
    end else begin
      en_q     <= en_d;
      irq_en_q <= irq_en_d;
    end
  end

  // Latched trip register.
  logic [N_LINES-1:0] trip_q;
  qtg_trip #(.N(N_LINES)) u_trip (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_q_i     (en_q),
    .ovl_s_i    (ovl_s),
    .hot_lo_s_i (hot_lo_s),
    .hot_hi_s_i (hot_hi_s),
    .trip_ok_o  (trip_q)
  );

  logic [N_LINES-1:0] sw_on;
  assign sw_on     = en_q & trip_q;
  assign sw_on_o   = sw_on;
  assign en_o      = en_q;
  assign trip_ok_o = trip_q;
  assign temp_hi_o = hot_hi_s;
  assign irq_n_o   = !(irq_en_q && |(ovl_s & sw_on));

  assert_hot_all_off_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    hot_hi_s |=> (sw_on_o == '0));
  assert_irq_needs_live_line_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !irq_n_o |-> (|sw_on_o));
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_en_wr_i && !irq_en_wdata_i) |=> irq_n_o);
  assert_write_no_bypass_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (en_wr_i && hot_hi_s) |=> (sw_on_o == '0));
endmodule

// File: tb/tb_quad_thermal_guard.sv
module tb_quad_thermal_guard;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_wr, irq_en_wr, irq_en_wdata, hot_lo, hot_hi;
  logic [3:0] en_wdata, ovl;
  logic [3:0] sw_on, en_rb, trip_rb;
  logic       temp_hi, irq_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_thermal_guard dut (
    .clk(clk), .rst_n(rst_n),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .irq_en_wr_i(irq_en_wr), .irq_en_wdata_i(irq_en_wdata),
    .ovl_raw_i(ovl), .hot_lo_raw_i(hot_lo), .hot_hi_raw_i(hot_hi),
    .sw_on_o(sw_on), .en_o(en_rb), .trip_ok_o(trip_rb),
    .temp_hi_o(temp_hi), .irq_n_o(irq_n)
  );

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(logic [3:0] v);
    en_wr = 1'b1; en_wdata = v;
    @(negedge clk);
    en_wr = 1'b0;
    settle(3);
  endtask

  task automatic wr_irq_en(logic v);
    irq_en_wr = 1'b1; irq_en_wdata = v;
    @(negedge clk);
    irq_en_wr = 1'b0;
    settle(3);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en_wr = 0; en_wdata = 0; irq_en_wr = 0; irq_en_wdata = 0;
    ovl = 0; hot_lo = 0; hot_hi = 0;
    settle(3);
    rst_n = 1'b1;
    settle(4);
    chk("R1 sw_on", sw_on, 4'b0000);
    chk("R1 enable", en_rb, 4'b0000);
    chk("R1 trip", trip_rb, 4'b1111);
    chk("R1 temp", {3'b0, temp_hi}, 4'b0000);
    chk("R1 irq_n", {3'b0, irq_n}, 4'b0001);
  endtask

  task automatic t_basic_enable();
    wr_en(4'b1011);
    chk("R2 sw_on follows enable", sw_on, 4'b1011);
    chk("R2 enable readback", en_rb, 4'b1011);
  endtask

  task automatic t_low_trip_and_latch();
    ovl = 4'b0011; hot_lo = 1'b1;
    settle(4);
    chk("R3 trip only overloaded", trip_rb, 4'b1100);
    chk("R3 sw_on", sw_on, 4'b1000);
    chk("R7 temp stays low", {3'b0, temp_hi}, 4'b0000);
    ovl = 4'b0000; hot_lo = 1'b0;
    settle(6);
    chk("R5 trip latched", trip_rb, 4'b1100);
    chk("R5 sw_on latched off", sw_on, 4'b1000);
  endtask

  task automatic t_restore();
    wr_en(4'b1000);
    chk("R6 trip restored after disable", trip_rb, 4'b1111);
    chk("R6 sw_on", sw_on, 4'b1000);
    wr_en(4'b1011);
    chk("R6 re-enable", sw_on, 4'b1011);
  endtask

  task automatic t_high_trip();
    hot_hi = 1'b1;
    settle(4);
    chk("R4 trip all", trip_rb, 4'b0000);
    chk("R4 sw_on all off", sw_on, 4'b0000);
    chk("R7 temp high", {3'b0, temp_hi}, 4'b0001);
    wr_en(4'b1111);
    chk("R10 enable readback", en_rb, 4'b1111);
    chk("R10 write has no effect", sw_on, 4'b0000);
    wr_en(4'b0000);
    chk("R6 no restore while hot", trip_rb, 4'b0000);
    hot_hi = 1'b0;
    settle(4);
    chk("R7 temp cleared", {3'b0, temp_hi}, 4'b0000);
    chk("R6 restore after cool", trip_rb, 4'b1111);
    wr_en(4'b0101);
    chk("R2 sw_on after cool", sw_on, 4'b0101);
  endtask

  task automatic t_irq();
    wr_irq_en(1'b1);
    chk("R8 idle irq", {3'b0, irq_n}, 4'b0001);
    ovl = 4'b0100; settle(3);
    chk("R8 irq asserted", {3'b0, irq_n}, 4'b0000);
    ovl = 4'b1000; settle(3);
    chk("R9 overload on off line", {3'b0, irq_n}, 4'b0001);
    ovl = 4'b0100; settle(3);
    wr_en(4'b0001);
    chk("R9 host off releases", {3'b0, irq_n}, 4'b0001);
    wr_en(4'b0101);
    chk("R8 irq again", {3'b0, irq_n}, 4'b0000);
    ovl = 4'b0000; settle(3);
    chk("R9 overload cleared", {3'b0, irq_n}, 4'b0001);
    ovl = 4'b0100; settle(3);
    wr_irq_en(1'b0);
    chk("R9 masked", {3'b0, irq_n}, 4'b0001);
    wr_irq_en(1'b1);
    chk("R8 unmasked", {3'b0, irq_n}, 4'b0000);
    hot_lo = 1'b1; settle(4);
    chk("R9 thermal trip releases", {3'b0, irq_n}, 4'b0001);
    chk("R3 sw_on after low trip", sw_on, 4'b0001);
    hot_lo = 1'b0; ovl = 4'b0000; settle(4);
    wr_en(4'b0111);
    chk("R10 set over tripped bit", sw_on, 4'b0011);
  endtask

  initial begin
    t_reset();
    t_basic_enable();
    t_low_trip_and_latch();
    t_restore();
    t_high_trip();
    t_irq();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end
endmodule